// File: doc/BRIEF.md
# Audio Transmit Sample Path

This block is the playback half of an audio codec interface. Software writes 32-bit words to a data register. Each word is unpacked into 20-bit left-justified samples according to a sample-size field and a compact-mode bit, and the samples are held in a circular buffer of parameterised depth. Once the buffer is at least half full, and while the transmit side is enabled, pairs leave it for the codec side: the left sample first, then the right.

The codec side is a valid/ready sink that takes one left/right pair per accepted cycle. The block keeps four status flags: empty, half-empty, full and underrun. From these it builds three raw interrupt causes, and it drives one interrupt line gated by a software mask. A write to the interface-enable register with bit 0 clear flushes the path back to its reset state.

Register selects (`reg_sel`): 0 control, 1 data, 2 interrupt clear, 3 interface enable, 4 interrupt mask. Any other select is ignored.

Top module: `aud_tx_path`

## Requirements
- R1: The control register holds the following fields: bit 0 transmit enable, bit 1 slot-3 enable, bit 2 slot-4 enable, bits [4:3] size and bit 5 compact. The size codes are 0 = 16-bit, 1 = 18-bit, 2 = 20-bit and 3 = 12-bit. In non-compact mode a data write stores one sample, equal to the word shifted left by (20 − width) and truncated to 20 bits.
- R2: In compact mode a data write stores two samples, bits [15:0] first and then bits [31:16]. Each half is shifted left by 8 for 12-bit size and by 4 for 16-bit size.
- R3: A compact request made together with 18-bit or 20-bit size is ignored, and the data writes that follow each store one sample.
- R4: A non-compact data write is stored only while level < DEPTH. When level = DEPTH the write is dropped and the level does not change.
- R5: A compact data write is stored only while level + 2 < DEPTH. Otherwise both halves are dropped.
- R6: After a push, empty and underrun clear if the level is above 0. Half-empty clears if the level is ≥ DEPTH/2. Full sets if the level is ≥ DEPTH.
- R7: `snk_valid` rises only when transmit enable is set, at least one slot enable is set, and level ≥ DEPTH/2. Once a pair has been accepted, draining continues while at least 2 entries remain. Samples leave in write order, left then right.
- R8: While `snk_ready` is low, no entry leaves the buffer. A refused offer ends the burst.
- R9: After a pair leaves, full clears. Half-empty sets if level ≤ DEPTH/2. Empty and underrun both set if the level reaches 0.
- R10: `int_raw` bit 0 equals half-empty, bit 1 equals underrun, and bit 2 equals empty AND NOT `snk_valid`. `irq` is the OR of `int_raw` ANDed with the 3-bit mask, whose bits line up with the `int_raw` bits.
- R11: Writing the interrupt-clear register with bit 1 set clears underrun. Writing it with bit 1 clear leaves underrun unchanged.
- R12: After reset, or after an interface-enable write with bit 0 = 0, the block is in the flushed state. In this state the level is 0, empty and half-empty are 1, full and underrun are 0, and the control fields and the mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| snk_valid | output | 1 | Pair offered to the codec side |
| snk_ready | input | 1 | Codec side accepts the pair |
| snk_left | output | 20 | Left sample |
| snk_right | output | 20 | Right sample |
| fifo_level | output | $clog2(DEPTH)+1 | Entries held |
| st_empty | output | 1 | Empty flag |
| st_half | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |
| int_raw | output | 3 | Raw interrupt causes |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions assume that DEPTH is a power of two no smaller than 4. They also assume that `snk_ready` is only meaningful while `snk_valid` is high, so a ready with nothing offered moves no data. The bench drives every input on the falling edge and holds `snk_ready` low whenever it fills the buffer. As a result, a push and a drain only coincide in the cases that are meant to test that overlap. Register writes always use the defined selects, except where a write is meant to be ignored.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SMP_W = 20;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_ICLR  = 3'd2,
    SEL_MAIN  = 3'd3,
    SEL_IMASK = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } smp_size_e;

  typedef struct packed {
    logic      en;
    logic      slot3;
    logic      slot4;
    smp_size_e size;
    logic      compact;
  } tx_cfg_t;

  localparam int INT_TX   = 0;
  localparam int INT_UND  = 1;
  localparam int INT_DONE = 2;

  // left shift that brings a sample of the given width to 20 bits
  function automatic logic [4:0] pad_shift(smp_size_e sz);
    case (sz)
      SZ12:    return 5'd8;
      SZ16:    return 5'd4;
      SZ18:    return 5'd2;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [SMP_W-1:0] widen(logic [31:0] raw, smp_size_e sz);
    logic [31:0] t;
    t = raw << pad_shift(sz);
    return t[SMP_W-1:0];
  endfunction

  function automatic logic compact_legal(smp_size_e sz);
    return (sz == SZ16) || (sz == SZ12);
  endfunction
endpackage

// File: rtl/aud_tx_regs.sv
module aud_tx_regs
  import aud_tx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output tx_cfg_t       cfg,
  output logic [2:0]    imask,
  output logic          data_push,
  output logic [31:0]   data_word,
  output logic          und_clr,
  output logic          flush
);
  logic wr_ctrl, wr_mask;
  smp_size_e new_size;

  assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_mask   = reg_wr && (reg_sel == SEL_IMASK);
  assign data_push = reg_wr && (reg_sel == SEL_DATA);
  assign data_word = reg_wdata;
  assign und_clr   = reg_wr && (reg_sel == SEL_ICLR) && reg_wdata[INT_UND];
  assign flush     = reg_wr && (reg_sel == SEL_MAIN) && !reg_wdata[0];
  assign new_size  = smp_size_e'(reg_wdata[4:3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      imask <= '0;
    end else if (flush) begin
      cfg   <= '0;
      imask <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.en      <= reg_wdata[0];
        cfg.slot3   <= reg_wdata[1];
        cfg.slot4   <= reg_wdata[2];
        cfg.size    <= new_size;
        cfg.compact <= reg_wdata[5] && compact_legal(new_size);
      end
      if (wr_mask) imask <= reg_wdata[2:0];
    end
  end

  // R3: compact mode never survives with an 18/20-bit size
  a_r3_compact_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.compact |-> (cfg.size == SZ16 || cfg.size == SZ12));

  // R12: a flush leaves the mask cleared
  a_r12_flush_mask: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (imask == 3'd0 && !cfg.en));
endmodule

// File: rtl/aud_tx_unpack.sv
module aud_tx_unpack
  import aud_tx_pkg::*;
(
  input  tx_cfg_t           cfg,
  input  logic [31:0]       word,
  output logic              pair,
  output logic [SMP_W-1:0]  smp0,
  output logic [SMP_W-1:0]  smp1
);
  assign pair = cfg.compact;

  always_comb begin
    if (cfg.compact) begin
      smp0 = widen({16'd0, word[15:0]}, cfg.size);
      smp1 = widen({16'd0, word[31:16]}, cfg.size);
    end else begin
      smp0 = widen(word, cfg.size);
      smp1 = '0;
    end
  end
endmodule

// File: rtl/aud_tx_sbuf.sv
module aud_tx_sbuf
  import aud_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push_req,
  input  logic                     push_pair,
  input  logic [SMP_W-1:0]         smp0,
  input  logic [SMP_W-1:0]         smp1,
  input  logic                     pop,
  output logic [SMP_W-1:0]         out_l,
  output logic [SMP_W-1:0]         out_r,
  output logic [$clog2(DEPTH):0]   level,
  output logic [1:0]               n_push
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [SMP_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wp1, rp1;
  logic accept;

  assign wp1 = wptr + 1'b1;
  assign rp1 = rptr + 1'b1;

  always_comb begin
    if (push_pair) accept = push_req && (level < FULL_LVL - LW'(2));
    else           accept = push_req && (level < FULL_LVL);
  end

  assign n_push = !accept ? 2'd0 : (push_pair ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wptr] <= smp0;
      if (push_pair) mem[wp1] <= smp1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      wptr  <= wptr + AW'(n_push);
      if (pop) rptr <= rptr + AW'(2);
      level <= level + LW'(n_push) - (pop ? LW'(2) : LW'(0));
    end
  end

  assign out_l = mem[rptr];
  assign out_r = mem[rp1];

  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);

  a_r4_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !push_pair && level == FULL_LVL) |=> level <= $past(level));

  a_r5_compact_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && push_pair && level >= FULL_LVL - LW'(2)) |=> level <= $past(level));

  a_r7_pop_has_pair: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level >= LW'(2));
endmodule

// File: rtl/aud_tx_flags.sv
module aud_tx_flags
  import aud_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  tx_cfg_t                 cfg,
  input  logic [$clog2(DEPTH):0]  level,
  input  logic [1:0]              n_push,
  input  logic                    und_clr,
  input  logic [2:0]              imask,
  input  logic                    snk_ready,
  output logic                    snk_valid,
  output logic                    pop,
  output logic                    st_empty,
  output logic                    st_half,
  output logic                    st_full,
  output logic                    st_underrun,
  output logic [2:0]              int_raw,
  output logic                    irq
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH / 2);

  logic drain_on, burst, burst_n, refused;
  logic [LW-1:0] lvl_push, lvl_after;
  logic e_n, h_n, f_n, u_n;

  assign drain_on  = cfg.en && (cfg.slot3 || cfg.slot4);
  assign snk_valid = drain_on && (level >= LW'(2)) && (burst || level >= HALF_LVL);
  assign pop       = snk_valid && snk_ready;
  assign refused   = snk_valid && !snk_ready;
  assign lvl_push  = level + LW'(n_push);
  assign lvl_after = lvl_push - (pop ? LW'(2) : LW'(0));

  always_comb begin
    e_n = st_empty;
    h_n = st_half;
    f_n = st_full;
    u_n = st_underrun;
    if (n_push != 2'd0) begin
      if (lvl_push != '0) begin
        e_n = 1'b0;
        u_n = 1'b0;
      end
      if (lvl_push >= HALF_LVL) h_n = 1'b0;
      if (lvl_push >= FULL_LVL) f_n = 1'b1;
    end
    if (pop) begin
      f_n = 1'b0;
      if (lvl_after <= HALF_LVL) h_n = 1'b1;
      if (lvl_after == '0) begin
        e_n = 1'b1;
        u_n = 1'b1;
      end
    end
    if (und_clr) u_n = 1'b0;
  end

  always_comb begin
    burst_n = burst;
    if (refused)  burst_n = 1'b0;
    else if (pop) burst_n = (lvl_after >= LW'(2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_empty <= 1'b1; st_half <= 1'b1; st_full <= 1'b0; st_underrun <= 1'b0;
      burst    <= 1'b0;
    end else if (flush) begin
      st_empty <= 1'b1; st_half <= 1'b1; st_full <= 1'b0; st_underrun <= 1'b0;
      burst    <= 1'b0;
    end else begin
      st_empty <= e_n; st_half <= h_n; st_full <= f_n; st_underrun <= u_n;
      burst    <= burst_n;
    end
  end

  always_comb begin
    int_raw           = '0;
    int_raw[INT_TX]   = st_half;
    int_raw[INT_UND]  = st_underrun;
    int_raw[INT_DONE] = st_empty && !snk_valid;
  end
  assign irq = |(int_raw & imask);

  a_r6_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    st_full == (level == FULL_LVL));

  a_r9_empty_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty == (level == '0));

  a_r9_underrun_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_underrun) |-> st_empty);

  a_r8_refuse_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (refused && !flush) |=> level >= $past(level));

  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imask != 3'd0));

  a_r11_und_clear: assert property (@(posedge clk) disable iff (!rst_n)
    und_clr |=> !st_underrun);
endmodule

// File: rtl/aud_tx_path.sv
module aud_tx_path
  import aud_tx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [2:0]              reg_sel,
  input  logic [31:0]             reg_wdata,
  output logic                    snk_valid,
  input  logic                    snk_ready,
  output logic [19:0]             snk_left,
  output logic [19:0]             snk_right,
  output logic [$clog2(DEPTH):0]  fifo_level,
  output logic                    st_empty,
  output logic                    st_half,
  output logic                    st_full,
  output logic                    st_underrun,
  output logic [2:0]              int_raw,
  output logic                    irq
);
  tx_cfg_t cfg;
  logic [2:0] imask;
  logic data_push, und_clr, flush, pair, pop;
  logic [31:0] data_word;
  logic [SMP_W-1:0] smp0, smp1;
  logic [1:0] n_push;

  aud_tx_regs u_regs (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata,
    .cfg, .imask, .data_push, .data_word, .und_clr, .flush
  );

  aud_tx_unpack u_unpack (
    .cfg, .word(data_word), .pair, .smp0, .smp1
  );

  aud_tx_sbuf #(.DEPTH(DEPTH)) u_sbuf (
    .clk, .rst_n, .flush, .push_req(data_push), .push_pair(pair),
    .smp0, .smp1, .pop, .out_l(snk_left), .out_r(snk_right),
    .level(fifo_level), .n_push
  );

  aud_tx_flags #(.DEPTH(DEPTH)) u_flags (
    .clk, .rst_n, .flush, .cfg, .level(fifo_level), .n_push, .und_clr,
    .imask, .snk_ready, .snk_valid, .pop, .st_empty, .st_half, .st_full,
    .st_underrun, .int_raw, .irq
  );
endmodule

// File: tb/aud_tx_path_tb_top.sv
module aud_tx_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic snk_ready = 1'b0;
  logic snk_valid, st_empty, st_half, st_full, st_underrun, irq;
  logic [19:0] snk_left, snk_right;
  logic [3:0] fifo_level;
  logic [2:0] int_raw;

  int checks = 0;
  int fails = 0;
  logic [19:0] cap_l [64];
  logic [19:0] cap_r [64];
  int cap_n = 0;
  logic [31:0] words [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_tx_path #(.DEPTH(DEPTH)) dut_i (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .snk_valid, .snk_ready,
    .snk_left, .snk_right, .fifo_level, .st_empty, .st_half, .st_full,
    .st_underrun, .int_raw, .irq
  );

  // capture accepted pairs, sampled after the falling edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (snk_valid && snk_ready && cap_n < 64) begin
        cap_l[cap_n] = snk_left;
        cap_r[cap_n] = snk_right;
        cap_n = cap_n + 1;
      end
    end
  end

  function automatic logic [19:0] exp_nc(int sz, logic [31:0] d);
    int bits;
    logic [63:0] w;
    bits = (sz == 0) ? 16 : (sz == 1) ? 18 : (sz == 2) ? 20 : 12;
    w = {32'd0, d} << (20 - bits);
    return w[19:0];
  endfunction

  function automatic logic [19:0] exp_cp(int sz, logic [15:0] h);
    int bits;
    logic [63:0] w;
    bits = (sz == 3) ? 12 : 16;
    w = {48'd0, h} << (20 - bits);
    return w[19:0];
  endfunction

  function automatic logic [31:0] ctrl_w(bit en, bit s3, bit s4, int sz, bit cp);
    logic [1:0] szb;
    szb = sz[1:0];
    return {26'd0, cp, szb, s4, s3, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_ready(logic v);
    @(negedge clk);
    snk_ready = v;
    #1;
  endtask

  task automatic flags(string tag, logic e, logic h, logic f, logic u);
    check({tag, " empty"}, 32'(st_empty), 32'(e));
    check({tag, " half"},  32'(st_half),  32'(h));
    check({tag, " full"},  32'(st_full),  32'(f));
    check({tag, " underrun"}, 32'(st_underrun), 32'(u));
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R12: reset state
    check("R12 reset level", 32'(fifo_level), 0);
    flags("R12 reset", 1, 1, 0, 0);
    check("R12 reset irq", 32'(irq), 0);
    check("R10 reset int_raw", 32'(int_raw), 5);
    check("R12 reset valid", 32'(snk_valid), 0);

    // R1 R4 R6 R9: non-compact sweep over every size code
    for (int sz = 0; sz < 4; sz++) begin
      wr(3'd3, 32'd0);
      set_ready(1'b0);
      wr(3'd0, ctrl_w(1, 1, 0, sz, 0));
      for (int i = 0; i < 9; i++) begin
        words[i] = 32'hA5C3_0000 ^ (32'(i) * 32'h0001_3579) ^ (32'(sz) * 32'h0024_6811);
        wr(3'd1, words[i]);
        if (i == 2) check("R6 half kept below depth/2", 32'(st_half), 1);
        if (i == 3) check("R6 half cleared at depth/2", 32'(st_half), 0);
        if (i == 0) check("R6 empty cleared", 32'(st_empty), 0);
      end
      check("R4 level capped at depth", 32'(fifo_level), 8);
      check("R6 full set", 32'(st_full), 1);
      idle(3);
      check("R8 no drain while not ready", 32'(fifo_level), 8);
      check("R8 pair offered", 32'(snk_valid), 1);
      base = cap_n;
      set_ready(1'b1);
      idle(6);
      set_ready(1'b0);
      check("R7 pairs drained", 32'(cap_n - base), 4);
      for (int k = 0; k < 4; k++) begin
        check("R1 left sample", 32'(cap_l[base+k]), 32'(exp_nc(sz, words[2*k])));
        check("R1 right sample", 32'(cap_r[base+k]), 32'(exp_nc(sz, words[2*k+1])));
      end
      check("R9 level zero", 32'(fifo_level), 0);
      flags("R9 after drain", 1, 1, 0, 1);
    end

    // R2 R5: compact mode for 16-bit and 12-bit sizes
    for (int sz = 0; sz < 4; sz += 3) begin
      wr(3'd3, 32'd0);
      set_ready(1'b0);
      wr(3'd0, ctrl_w(1, 0, 1, sz, 1));
      for (int i = 0; i < 4; i++) begin
        words[i] = 32'h8F31_C2D7 + 32'(i) * 32'h1111_0F0F + 32'(sz);
        wr(3'd1, words[i]);
      end
      check("R5 compact level stops short of depth", 32'(fifo_level), 6);
      check("R5 compact never full", 32'(st_full), 0);
      base = cap_n;
      set_ready(1'b1);
      idle(5);
      set_ready(1'b0);
      check("R2 compact pairs", 32'(cap_n - base), 3);
      for (int k = 0; k < 3; k++) begin
        check("R2 low half first", 32'(cap_l[base+k]), 32'(exp_cp(sz, words[k][15:0])));
        check("R2 high half second", 32'(cap_r[base+k]), 32'(exp_cp(sz, words[k][31:16])));
      end
    end

    // R3 R7: compact with wide sizes stores one sample; threshold
    wr(3'd3, 32'd0);
    set_ready(1'b1);
    words[0] = 32'h000F_1234; words[1] = 32'hFFF9_8765;
    words[2] = 32'h1234_ABCD; words[3] = 32'h0007_0001;
    wr(3'd0, ctrl_w(1, 1, 0, 1, 1));
    wr(3'd1, words[0]);
    check("R3 18-bit compact stores one", 32'(fifo_level), 1);
    wr(3'd0, ctrl_w(1, 1, 0, 2, 1));
    wr(3'd1, words[1]);
    check("R3 20-bit compact stores one", 32'(fifo_level), 2);
    idle(2);
    check("R7 no drain below depth/2", 32'(snk_valid), 0);
    check("R7 level kept below depth/2", 32'(fifo_level), 2);
    base = cap_n;
    wr(3'd1, words[2]);
    wr(3'd1, words[3]);
    idle(4);
    check("R7 burst empties buffer", 32'(fifo_level), 0);
    check("R7 burst pair count", 32'(cap_n - base), 2);
    check("R3 sample 0", 32'(cap_l[base]), 32'(exp_nc(1, words[0])));
    check("R3 sample 1", 32'(cap_r[base]), 32'(exp_nc(2, words[1])));
    check("R7 order sample 2", 32'(cap_l[base+1]), 32'(exp_nc(2, words[2])));
    check("R7 order sample 3", 32'(cap_r[base+1]), 32'(exp_nc(2, words[3])));

    // R7: enables gate the drain
    wr(3'd0, ctrl_w(1, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) wr(3'd1, 32'(i + 1));
    idle(2);
    check("R7 no slots no drain", 32'(snk_valid), 0);
    wr(3'd0, ctrl_w(0, 0, 1, 0, 0));
    idle(2);
    check("R7 disabled no drain", 32'(snk_valid), 0);
    check("R7 disabled level held", 32'(fifo_level), 4);
    wr(3'd0, ctrl_w(1, 0, 1, 0, 0));
    idle(4);
    check("R7 slot4 drains", 32'(fifo_level), 0);

    // R8 R9: one-cycle accept then refusal
    set_ready(1'b0);
    for (int i = 0; i < 8; i++) wr(3'd1, 32'(i * 7));
    set_ready(1'b1);
    set_ready(1'b0);
    check("R8 one pair per accept", 32'(fifo_level), 6);
    flags("R9 level 6", 0, 0, 0, 0);
    idle(2);
    check("R8 stays at 6 while refused", 32'(fifo_level), 6);
    set_ready(1'b1);
    set_ready(1'b0);
    check("R9 level 4", 32'(fifo_level), 4);
    check("R9 half set at depth/2", 32'(st_half), 1);
    set_ready(1'b1);
    idle(4);
    set_ready(1'b0);
    flags("R9 drained", 1, 1, 0, 1);

    // R10 R11: interrupts
    wr(3'd4, 32'd2);
    check("R10 underrun irq", 32'(irq), 1);
    check("R10 raw all", 32'(int_raw), 7);
    wr(3'd2, 32'd5);
    check("R11 other bits keep underrun", 32'(st_underrun), 1);
    wr(3'd2, 32'd2);
    check("R11 underrun cleared", 32'(st_underrun), 0);
    check("R10 irq drops", 32'(irq), 0);
    wr(3'd4, 32'd4);
    check("R10 complete irq", 32'(irq), 1);
    wr(3'd0, ctrl_w(1, 0, 0, 0, 0));
    wr(3'd1, 32'h55);
    check("R10 complete gone after push", 32'(irq), 0);
    check("R10 raw half only", 32'(int_raw), 1);
    wr(3'd4, 32'd1);
    check("R10 half-empty irq", 32'(irq), 1);

    // R12: flush through interface enable
    wr(3'd1, 32'h66);
    wr(3'd1, 32'h77);
    wr(3'd3, 32'd1);
    check("R12 enable write keeps level", 32'(fifo_level), 3);
    wr(3'd3, 32'd0);
    check("R12 flush level", 32'(fifo_level), 0);
    flags("R12 flush", 1, 1, 0, 0);
    check("R12 flush mask", 32'(irq), 0);
    set_ready(1'b1);
    for (int i = 0; i < 4; i++) wr(3'd1, 32'(i));
    idle(2);
    check("R12 flush cleared enables", 32'(snk_valid), 0);
    check("R12 pushes after flush", 32'(fifo_level), 4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule